// File: doc/BRIEF.md
# Periodic Split-Transaction Queue-Head Sequencer

This block keeps the scheduling fields of a single periodic interrupt queue head and acts on them once per microframe. A strobe marks each microframe boundary, and the microframe index arrives with it. The low three bits of the index select a microframe slot within the frame. The bits above those give the frame number. An eight-bit start mask and an eight-bit complete mask choose the slots in which a start-split or a complete-split may go out. A request is a one-cycle pulse. A completion input (done, plus an ok flag) reports the outcome of the bus transaction.

Software writes every control field at once through a register-style port. To stop the queue head safely, software sets the inactivate bit, and the sequencer then drops Active at a point where no split is in progress. To bring the queue head back, software makes three writes: set Halted, clear inactivate, then set Active and clear Halted in one write. The block also keeps a frame tag. It loads the tag from the frame number of the issuing microframe and moves it on by one frame when the split crosses the frame boundary.

Top module: `qh_split_seq`

States of the controller: `ST_IDLE` waits for a microframe strobe; `ST_WAIT_SS` waits for the start-split result; `ST_WAIT_CS` waits for the complete-split result. Transitions: `ST_IDLE`→`ST_WAIT_SS` on a start-split issue; `ST_IDLE`→`ST_WAIT_CS` on a complete-split issue; either wait state→`ST_IDLE` on `xact_done`. The split phase is a separate bit: 0 means start phase (DoStart), 1 means complete phase (DoComplete).

## Requirements
- R1: After reset, masks, Active, Halted, inactivate, split phase (0 = start) and frame tag are all zero, and neither request is asserted.
- R2: In a microframe where Active is 0, no start-split or complete-split request is made.
- R3: On a strobe in `ST_IDLE`, in start phase, with Active=1, Halted=0, inactivate=0 and start-mask bit [frindex[2:0]] set, `ss_req` pulses in the cycle after the strobe edge. A later `xact_done` with `xact_ok`=1 moves the split phase to 1. With `xact_ok`=0 the phase stays 0.
- R4: On a strobe in `ST_IDLE`, in complete phase, with Active=1, Halted=0 and complete-mask bit [frindex[2:0]] set, `cs_req` pulses in the cycle after the strobe edge. A later `xact_done` with `xact_ok`=1 (split finished) returns the phase to 0. With `xact_ok`=0 the phase stays 1.
- R5: While Halted=1, no request is made and no field changes at a strobe.
- R6: A strobe in start phase with Active=1, Halted=0 and inactivate=1 clears Active and makes no start-split, whatever the start mask holds.
- R7: With inactivate=1 in complete phase, scheduled complete-splits still go out. The completion that finishes the split clears Active, and no start-split follows.
- R8: A write that would change both Active and inactivate leaves both unchanged. Its masks and Halted are still taken.
- R9: The three-write sequence (set Halted; clear inactivate; set Active and clear Halted) reactivates a stopped queue head, and start-splits resume.
- R10: When a start-split completes with ok, the frame tag becomes frindex[7:3] of the issuing strobe if frindex[2:0] was not 6, and that value plus one (modulo 32) if it was 6.
- R11: When a complete-split completes in complete phase, the frame tag becomes frindex[7:3] of the issuing strobe if frindex[2:0] was not 7, and that value plus one if it was 7.
- R12: Each request lasts exactly one cycle, and `ss_req` and `cs_req` are never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| uf_tick | input | 1 | Microframe boundary strobe |
| frindex | input | 14 | Microframe index; [2:0] slot, [7:3] frame |
| wr_en | input | 1 | Write strobe for all control fields |
| wr_smask | input | 8 | Start mask to write |
| wr_cmask | input | 8 | Complete mask to write |
| wr_active | input | 1 | Active bit to write |
| wr_halted | input | 1 | Halted bit to write |
| wr_inact | input | 1 | Inactivate bit to write |
| xact_done | input | 1 | Result of the outstanding split transaction |
| xact_ok | input | 1 | Start accepted / split finished |
| ss_req | output | 1 | Start-split request pulse |
| cs_req | output | 1 | Complete-split request pulse |
| q_smask | output | 8 | Current start mask |
| q_cmask | output | 8 | Current complete mask |
| q_active | output | 1 | Current Active bit |
| q_halted | output | 1 | Current Halted bit |
| q_inact | output | 1 | Current inactivate bit |
| q_split | output | 1 | Split phase, 1 = complete phase |
| q_tag | output | 5 | Frame tag |

## Verification
The main function gets microframe strobes at slots both inside and outside each mask. This tells mask decoding apart from issuing on every strobe, and it tells the start mask apart from the complete mask. Completions arrive with ok both set and clear, which separates a phase change from a retry. The issuing slot is placed at 6, 7, 0 and 5, so a tag rule applied in the wrong phase or at the wrong slot shows up as an off-by-one tag. Inactivate is raised in each phase, so an early clear of Active can be told apart from the deferred clear.

// File: rtl/qh_pkg.sv
package qh_pkg;
    localparam int QH_MASK_W = 8;
    localparam int QH_TAG_W  = 5;
    localparam int QH_IDX_W  = 14;

    typedef enum logic [1:0] {
        ST_IDLE    = 2'd0,
        ST_WAIT_SS = 2'd1,
        ST_WAIT_CS = 2'd2
    } qh_state_e;
endpackage

// File: rtl/qh_ctl_regs.sv
module qh_ctl_regs #(
    parameter int MASK_W = qh_pkg::QH_MASK_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [MASK_W-1:0] wr_smask,
    input  logic [MASK_W-1:0] wr_cmask,
    input  logic              wr_active,
    input  logic              wr_halted,
    input  logic              wr_inact,
    input  logic              hw_clr_active,
    output logic [MASK_W-1:0] smask,
    output logic [MASK_W-1:0] cmask,
    output logic              active,
    output logic              halted,
    output logic              inact
);
    logic both_flip;
    logic active_d;
    logic inact_d;

    // A write that flips Active and inactivate together is refused for those two bits.
    always_comb begin
        both_flip = (wr_active != active) && (wr_inact != inact);
        active_d  = active;
        inact_d   = inact;
        if (wr_en && !both_flip) begin
            active_d = wr_active;
            inact_d  = wr_inact;
        end
        // The sequencer's deactivation wins over a same-cycle write.
        if (hw_clr_active) begin
            active_d = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            smask  <= '0;
            cmask  <= '0;
            active <= 1'b0;
            halted <= 1'b0;
            inact  <= 1'b0;
        end else begin
            active <= active_d;
            inact  <= inact_d;
            if (wr_en) begin
                smask  <= wr_smask;
                cmask  <= wr_cmask;
                halted <= wr_halted;
            end
        end
    end
endmodule

// File: rtl/qh_slot_sel.sv
module qh_slot_sel #(
    parameter int MASK_W = qh_pkg::QH_MASK_W,
    localparam int UF_W  = $clog2(MASK_W)
) (
    input  logic [MASK_W-1:0] mask,
    input  logic [UF_W-1:0]   slot,
    output logic              hit
);
    logic [MASK_W-1:0] onehot;

    for (genvar g = 0; g < MASK_W; g++) begin : g_dec
        assign onehot[g] = (slot == g[UF_W-1:0]);
    end

    assign hit = |(onehot & mask);
endmodule

// File: rtl/qh_tag_calc.sv
module qh_tag_calc #(
    parameter int UF_W  = 3,
    parameter int TAG_W = qh_pkg::QH_TAG_W
) (
    input  logic             from_start,
    input  logic [UF_W-1:0]  slot,
    input  logic [TAG_W-1:0] frame,
    output logic [TAG_W-1:0] tag
);
    localparam logic [UF_W-1:0] LAST_SLOT = '1;
    localparam logic [UF_W-1:0] PEN_SLOT  = LAST_SLOT - 1'b1;

    logic late;

    // A split issued late in the frame finishes in the next one.
    always_comb begin
        late = from_start ? (slot == PEN_SLOT) : (slot == LAST_SLOT);
        tag  = late ? frame + 1'b1 : frame;
    end
endmodule

// File: rtl/qh_split_seq.sv
module qh_split_seq #(
    parameter int MASK_W  = qh_pkg::QH_MASK_W,
    parameter int TAG_W   = qh_pkg::QH_TAG_W,
    parameter int IDX_W   = qh_pkg::QH_IDX_W,
    localparam int UF_W   = $clog2(MASK_W)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              uf_tick,
    input  logic [IDX_W-1:0]  frindex,
    input  logic              wr_en,
    input  logic [MASK_W-1:0] wr_smask,
    input  logic [MASK_W-1:0] wr_cmask,
    input  logic              wr_active,
    input  logic              wr_halted,
    input  logic              wr_inact,
    input  logic              xact_done,
    input  logic              xact_ok,
    output logic              ss_req,
    output logic              cs_req,
    output logic [MASK_W-1:0] q_smask,
    output logic [MASK_W-1:0] q_cmask,
    output logic              q_active,
    output logic              q_halted,
    output logic              q_inact,
    output logic              q_split,
    output logic [TAG_W-1:0]  q_tag
);
    import qh_pkg::*;

    qh_state_e state_q, state_d;

    logic [UF_W-1:0]  slot_now;
    logic [TAG_W-1:0] frame_now;
    logic [UF_W-1:0]  cap_slot_q;
    logic [TAG_W-1:0] cap_frame_q;
    logic             split_q;
    logic [TAG_W-1:0] tag_q;
    logic             ss_req_q, cs_req_q;

    logic s_hit, c_hit;
    logic eligible;
    logic issue_ss, issue_cs;
    logic clr_on_start, clr_on_finish, hw_clr;
    logic ss_ok, cs_fin, cs_retry;
    logic [TAG_W-1:0] tag_new;

    assign slot_now  = frindex[UF_W-1:0];
    assign frame_now = frindex[UF_W +: TAG_W];

    qh_ctl_regs #(.MASK_W(MASK_W)) u_regs (
        .clk           (clk),
        .rst_n         (rst_n),
        .wr_en         (wr_en),
        .wr_smask      (wr_smask),
        .wr_cmask      (wr_cmask),
        .wr_active     (wr_active),
        .wr_halted     (wr_halted),
        .wr_inact      (wr_inact),
        .hw_clr_active (hw_clr),
        .smask         (q_smask),
        .cmask         (q_cmask),
        .active        (q_active),
        .halted        (q_halted),
        .inact         (q_inact)
    );

    qh_slot_sel #(.MASK_W(MASK_W)) u_ssel (
        .mask (q_smask),
        .slot (slot_now),
        .hit  (s_hit)
    );

    qh_slot_sel #(.MASK_W(MASK_W)) u_csel (
        .mask (q_cmask),
        .slot (slot_now),
        .hit  (c_hit)
    );

    qh_tag_calc #(.UF_W(UF_W), .TAG_W(TAG_W)) u_tag (
        .from_start (state_q == ST_WAIT_SS),
        .slot       (cap_slot_q),
        .frame      (cap_frame_q),
        .tag        (tag_new)
    );

    // Decode of this cycle's events and the next state.
    always_comb begin
        eligible      = (state_q == ST_IDLE) && uf_tick && q_active && !q_halted;
        issue_ss      = eligible && !split_q && !q_inact && s_hit;
        issue_cs      = eligible && split_q && c_hit;
        clr_on_start  = eligible && !split_q && q_inact;
        ss_ok         = (state_q == ST_WAIT_SS) && xact_done && xact_ok;
        cs_fin        = (state_q == ST_WAIT_CS) && xact_done && xact_ok;
        cs_retry      = (state_q == ST_WAIT_CS) && xact_done && !xact_ok;
        clr_on_finish = cs_fin && q_inact;
        hw_clr        = clr_on_start || clr_on_finish;

        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (issue_ss)      state_d = ST_WAIT_SS;
                else if (issue_cs) state_d = ST_WAIT_CS;
            end
            ST_WAIT_SS: if (xact_done) state_d = ST_IDLE;
            ST_WAIT_CS: if (xact_done) state_d = ST_IDLE;
            default:    state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // Registered outputs, split phase, capture and frame tag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ss_req_q    <= 1'b0;
            cs_req_q    <= 1'b0;
            split_q     <= 1'b0;
            tag_q       <= '0;
            cap_slot_q  <= '0;
            cap_frame_q <= '0;
        end else begin
            ss_req_q <= issue_ss;
            cs_req_q <= issue_cs;
            if (issue_ss || issue_cs) begin
                cap_slot_q  <= slot_now;
                cap_frame_q <= frame_now;
            end
            if (ss_ok) begin
                split_q <= 1'b1;
                tag_q   <= tag_new;
            end
            if (cs_fin) begin
                split_q <= 1'b0;
            end
            if (cs_retry) begin
                tag_q <= tag_new;
            end
        end
    end

    assign ss_req  = ss_req_q;
    assign cs_req  = cs_req_q;
    assign q_split = split_q;
    assign q_tag   = tag_q;
endmodule

// File: rtl/qh_split_seq_chk.sv
module qh_split_seq_chk (
    input logic clk,
    input logic rst_n,
    input logic uf_tick,
    input logic busy,
    input logic wr_en,
    input logic wr_active,
    input logic wr_inact,
    input logic ss_req,
    input logic cs_req,
    input logic q_active,
    input logic q_halted,
    input logic q_inact,
    input logic q_split
);
    assert_no_req_inactive_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (ss_req || cs_req) |-> $past(q_active));

    assert_ss_gated_R3: assert property (@(posedge clk) disable iff (!rst_n)
        ss_req |-> $past(q_active && !q_halted && !q_inact && !q_split));

    assert_cs_gated_R4: assert property (@(posedge clk) disable iff (!rst_n)
        cs_req |-> $past(q_active && !q_halted && q_split));

    assert_inact_start_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (uf_tick && !busy && q_active && !q_halted && q_inact && !q_split) |=> !q_active);

    assert_reject_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && (wr_active != q_active) && (wr_inact != q_inact))
        |=> (q_inact == $past(q_inact)) && !$rose(q_active));

    assert_req_pulse_R12: assert property (@(posedge clk) disable iff (!rst_n)
        (ss_req || cs_req) |=> !(ss_req || cs_req));

    assert_req_exclusive_R12: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({ss_req, cs_req}));
endmodule

bind qh_split_seq qh_split_seq_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .uf_tick   (uf_tick),
    .busy      (state_q != qh_pkg::ST_IDLE),
    .wr_en     (wr_en),
    .wr_active (wr_active),
    .wr_inact  (wr_inact),
    .ss_req    (ss_req),
    .cs_req    (cs_req),
    .q_active  (q_active),
    .q_halted  (q_halted),
    .q_inact   (q_inact),
    .q_split   (q_split)
);

// File: tb/qh_split_seq_bench.sv
module qh_split_seq_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        uf_tick = 1'b0;
    logic [13:0] frindex = '0;
    logic        wr_en = 1'b0;
    logic [7:0]  wr_smask = '0;
    logic [7:0]  wr_cmask = '0;
    logic        wr_active = 1'b0;
    logic        wr_halted = 1'b0;
    logic        wr_inact = 1'b0;
    logic        xact_done = 1'b0;
    logic        xact_ok = 1'b0;
    logic        ss_req, cs_req;
    logic [7:0]  q_smask, q_cmask;
    logic        q_active, q_halted, q_inact, q_split;
    logic [4:0]  q_tag;

    int n_tests = 0;
    int n_fail  = 0;

    always #2 clk = ~clk;

    qh_split_seq u_qh_split_seq (
        .clk(clk), .rst_n(rst_n), .uf_tick(uf_tick), .frindex(frindex),
        .wr_en(wr_en), .wr_smask(wr_smask), .wr_cmask(wr_cmask),
        .wr_active(wr_active), .wr_halted(wr_halted), .wr_inact(wr_inact),
        .xact_done(xact_done), .xact_ok(xact_ok),
        .ss_req(ss_req), .cs_req(cs_req),
        .q_smask(q_smask), .q_cmask(q_cmask), .q_active(q_active),
        .q_halted(q_halted), .q_inact(q_inact), .q_split(q_split), .q_tag(q_tag)
    );

    task automatic check(input string req, input string what, input int act, input int exp);
        n_tests++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic wr(input logic [7:0] s, input logic [7:0] c,
                      input logic a, input logic h, input logic i);
        @(negedge clk);
        wr_en = 1'b1; wr_smask = s; wr_cmask = c;
        wr_active = a; wr_halted = h; wr_inact = i;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    // Strobe one microframe; samples both requests right after the edge.
    task automatic tick(input int frame, input int slot, output logic ss, output logic cs);
        @(negedge clk);
        uf_tick = 1'b1;
        frindex = 14'((frame << 3) | slot);
        @(negedge clk);
        uf_tick = 1'b0;
        ss = ss_req;
        cs = cs_req;
    endtask

    task automatic respond(input logic ok);
        @(negedge clk);
        xact_done = 1'b1; xact_ok = ok;
        @(negedge clk);
        xact_done = 1'b0; xact_ok = 1'b0;
    endtask

    task automatic t_reset();
        do_reset();
        check("R1", "smask", q_smask, 0);
        check("R1", "cmask", q_cmask, 0);
        check("R1", "active/halted/inact", {q_active, q_halted, q_inact}, 0);
        check("R1", "split/tag", {q_split, q_tag}, 0);
        check("R1", "requests", {ss_req, cs_req}, 0);
    endtask

    task automatic t_inactive();
        logic ss, cs;
        do_reset();
        wr(8'hFF, 8'hFF, 1'b0, 1'b0, 1'b0);
        tick(3, 2, ss, cs);
        check("R2", "no request while inactive", {ss, cs}, 0);
    endtask

    task automatic t_start_complete();
        logic ss, cs;
        do_reset();
        wr(8'h04, 8'h18, 1'b1, 1'b0, 1'b0);
        tick(5, 1, ss, cs);
        check("R3", "no ss outside start mask", ss, 0);
        tick(5, 2, ss, cs);
        check("R3", "ss on start mask slot", ss, 1);
        check("R12", "no cs with ss", cs, 0);
        @(negedge clk);
        check("R12", "ss one cycle", ss_req, 0);
        respond(1'b1);
        check("R3", "phase after ok start", q_split, 1);
        check("R10", "tag slot 2", q_tag, 5);
        tick(5, 2, ss, cs);
        check("R4", "no request off cmask in complete phase", {ss, cs}, 0);
        tick(5, 3, ss, cs);
        check("R4", "cs on cmask slot", cs, 1);
        respond(1'b0);
        check("R4", "phase after retry", q_split, 1);
        tick(5, 4, ss, cs);
        check("R4", "cs again", cs, 1);
        respond(1'b1);
        check("R4", "phase after finish", q_split, 0);
        check("R4", "still active", q_active, 1);
    endtask

    task automatic t_start_fail();
        logic ss, cs;
        do_reset();
        wr(8'h01, 8'h00, 1'b1, 1'b0, 1'b0);
        tick(2, 0, ss, cs);
        check("R3", "ss issued", ss, 1);
        respond(1'b0);
        check("R3", "phase stays start on failure", q_split, 0);
        tick(3, 0, ss, cs);
        check("R3", "ss reissued", ss, 1);
        respond(1'b1);
    endtask

    task automatic t_tags();
        logic ss, cs;
        do_reset();
        wr(8'h40, 8'h81, 1'b1, 1'b0, 1'b0);
        tick(9, 6, ss, cs);
        respond(1'b1);
        check("R10", "tag from slot 6 moves on", q_tag, 10);
        tick(9, 7, ss, cs);
        check("R4", "cs slot 7", cs, 1);
        respond(1'b0);
        check("R11", "tag from slot 7 moves on", q_tag, 10);
        tick(31, 7, ss, cs);
        respond(1'b0);
        check("R11", "tag wraps", q_tag, 0);
        tick(12, 0, ss, cs);
        respond(1'b0);
        check("R11", "tag slot 0", q_tag, 12);
        respond(1'b0);
        wr(8'h40, 8'h21, 1'b1, 1'b0, 1'b0);
        tick(20, 5, ss, cs);
        respond(1'b0);
        check("R11", "tag slot 5", q_tag, 20);
    endtask

    task automatic t_halted();
        logic ss, cs;
        do_reset();
        wr(8'hFF, 8'hFF, 1'b1, 1'b1, 1'b0);
        tick(1, 4, ss, cs);
        check("R5", "no request while halted", {ss, cs}, 0);
        check("R5", "active kept while halted", q_active, 1);
        wr(8'hFF, 8'hFF, 1'b1, 1'b1, 1'b1);
        tick(1, 5, ss, cs);
        check("R5", "halted blocks inactivate clear", q_active, 1);
    endtask

    task automatic t_inact_start_and_reactivate();
        logic ss, cs;
        do_reset();
        wr(8'h08, 8'h00, 1'b1, 1'b0, 1'b0);
        wr(8'h08, 8'h00, 1'b1, 1'b0, 1'b1);
        tick(4, 3, ss, cs);
        check("R6", "no ss with inactivate set", ss, 0);
        check("R6", "active cleared", q_active, 0);
        // Illegal write: flips both Active and inactivate, new masks.
        wr(8'h10, 8'h22, 1'b1, 1'b0, 1'b0);
        check("R8", "active/inact unchanged", {q_active, q_inact}, 2'b01);
        check("R8", "masks taken", {q_smask, q_cmask}, 16'h1022);
        // Reactivation sequence.
        wr(8'h10, 8'h22, 1'b0, 1'b1, 1'b1);
        wr(8'h10, 8'h22, 1'b0, 1'b1, 1'b0);
        check("R9", "after step 2", {q_active, q_halted, q_inact}, 3'b010);
        wr(8'h10, 8'h22, 1'b1, 1'b0, 1'b0);
        check("R9", "after step 3", {q_active, q_halted, q_inact}, 3'b100);
        tick(4, 4, ss, cs);
        check("R9", "ss resumes", ss, 1);
        respond(1'b1);
    endtask

    task automatic t_inact_complete();
        logic ss, cs;
        do_reset();
        wr(8'h01, 8'h06, 1'b1, 1'b0, 1'b0);
        tick(7, 0, ss, cs);
        respond(1'b1);
        wr(8'h01, 8'h06, 1'b1, 1'b0, 1'b1);
        tick(7, 1, ss, cs);
        check("R7", "cs continues with inactivate", cs, 1);
        respond(1'b0);
        check("R7", "active kept on retry", q_active, 1);
        tick(7, 2, ss, cs);
        check("R7", "cs again", cs, 1);
        respond(1'b1);
        check("R7", "active cleared on finish", q_active, 0);
        check("R7", "phase back to start", q_split, 0);
        tick(8, 0, ss, cs);
        check("R7", "no new ss", ss, 0);
    endtask

    initial begin : watchdog
        repeat (20000) @(posedge clk);
        n_tests++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin : main
        t_reset();
        t_inactive();
        t_start_complete();
        t_start_fail();
        t_tags();
        t_halted();
        t_inact_start_and_reactivate();
        t_inact_complete();
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule